// File: doc/BRIEF.md
# Programmable Colorspace Matrix with Window Rounding and Limiting

The block converts three 13-bit video channels through a 3x3 signed matrix and scales a fourth (key) channel with a coefficient of its own. Every clock a new pixel enters on four inputs. Four results leave four clock edges later. Four coefficient sets and four output-shaping sets are held in registers and loaded through a simple write port. Two 2-bit selects, sampled with each pixel, pick the coefficient set and the shaping set for that pixel only. Both selects travel down the pipeline with the data, so switching them on every clock is safe.

Each result is reduced to a 20-bit field taken from its most significant bits. A 13-bit window is cut out of that field at one of four positions. The window is rounded by adding half of its LSB, then clamped between a per-set floor and ceiling. A pass mode, also sampled per pixel, sends the four inputs to the outputs unchanged with the same latency, so processed and passed pixels can be mixed in one stream.

Top module: `csc_matrix_top`

## Requirements
- R1: While `rstN` is low all four outputs are 0. Reset leaves every coefficient at 0 and every shaping set at position 0, floor -4096, ceiling 4095.
- R2: A pixel presented before rising edge n appears on the outputs right after rising edge n+3, which is four edges of latency.
- R3: Data are 13-bit two's complement integers. Coefficients are 13-bit signed with LSB weight 2^-12, so 0x800 means 0.5. Row r gives out = sum over c of m[r][c]*in[c], where rows 0,1,2 drive `outW`,`outX`,`outY` and columns 0,1,2 are `inA`,`inB`,`inC`.
- R4: `outZ` is k*`inD`. Its 20-bit field is the product divided by 2^6, so its top bit carries weight 2^13.
- R5: The matrix field is the 3-term sum divided by 2^8, so its top bit carries weight 2^15. A window position p (0..3) takes field bits 19-p down to 7-p. The matrix output is therefore sum/2^(15-p) and the key output is product/2^(13-p).
- R6: Rounding adds half a window LSB before truncation toward minus infinity, so +1.5 gives 2 and -1.5 gives -1.
- R7: After rounding, a value below the set's floor gives the floor and a value above its ceiling gives the ceiling.
- R8: `coefSel` picks the coefficient set for the pixel sampled with it. It may change on every clock.
- R9: `rslSel` picks the shaping set for the pixel sampled with it. It may change on every clock.
- R10: A pixel sampled with `passMode` high leaves unchanged on the matching output, with the R2 latency.
- R11: A write with `wrEn` high uses `wrAddr` = {kind, set[1:0], index[3:0]}. Kind 0 with index 0..8 writes m[index/3][index%3], and index 9 writes k. Kind 1 with index 0 writes the position from `wrData[1:0]`, index 1 the floor and index 2 the ceiling. All other indices are ignored and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register address {kind, set, index} |
| wrData | input | 13 | Register write value |
| coefSel | input | 2 | Coefficient set for this pixel |
| rslSel | input | 2 | Shaping set for this pixel |
| passMode | input | 1 | Forward this pixel unprocessed |
| inA | input | 13 | Channel 0 input |
| inB | input | 13 | Channel 1 input |
| inC | input | 13 | Channel 2 input |
| inD | input | 13 | Key input |
| outW | output | 13 | Matrix row 0 result |
| outX | output | 13 | Matrix row 1 result |
| outY | output | 13 | Matrix row 2 result |
| outZ | output | 13 | Scaled key result |

## Verification
The assertions check three things on every cycle. Outputs are zero during reset. A passed pixel reappears exactly four edges later on `outW` and `outZ`. A processed result never falls outside the floor and ceiling of the shaping set that produced it. The bench scenarios cover everything that depends on the arithmetic: the matrix and key products, the four window positions, the rounding of exact halves, switching sets per clock, and ignored register addresses. These are checked against a model of R3 to R7 that the bench runs on its own copy of the written registers.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int DW    = 13;           // data width
  localparam int CW    = 13;           // coefficient width
  localparam int FW    = 20;           // field width fed to shaping
  localparam int NSETS = 4;
  localparam int SELW  = $clog2(NSETS);
  localparam int NCH   = 4;            // three matrix channels + key
  localparam int NROW  = 3;
  localparam int NCOEF = NROW * NROW + 1;
  localparam int PW    = DW + CW;      // product width
  localparam int SW    = PW + 2;       // three-term sum width
  localparam int GUARD = FW - DW;      // bits below the highest window
  localparam int POSW  = 2;            // window position field
  localparam int IDXW  = 4;
  localparam int AW    = 1 + SELW + IDXW;

  typedef logic signed [DW-1:0] data_t;
  typedef logic signed [CW-1:0] coef_t;
  typedef logic signed [PW-1:0] prod_t;
  typedef logic signed [SW-1:0] sum_t;
  typedef logic signed [FW-1:0] fld_t;

  typedef struct packed {
    logic [POSW-1:0] pos;
    logic [DW-1:0]   lo;
    logic [DW-1:0]   hi;
  } rsl_cfg_t;

  typedef struct packed {
    logic     bypass;   // pixel at the output stage is forwarded raw
    rsl_cfg_t rsl;      // shaping set for the pixel at the output stage
  } csc_ctrl_t;
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [SELW-1:0]  coefSel,
  input  logic [SELW-1:0]  rslSel,
  input  logic             passMode,
  output coef_t            coefAct [NCOEF],
  output csc_ctrl_t        ctrlBus
);
  localparam int DEPTH = 3;   // stages between sampling and output choice

  coef_t           coefBank [NSETS][NCOEF];
  rsl_cfg_t        rslBank  [NSETS];
  logic [SELW-1:0] coefSel1;
  logic [SELW-1:0] rslPipe  [DEPTH];
  logic [DEPTH-1:0] passPipe;

  logic            isRsl;
  logic [SELW-1:0] wrSet;
  logic [IDXW-1:0] wrIdx;
  assign isRsl = wrAddr[AW-1];
  assign wrSet = wrAddr[IDXW +: SELW];
  assign wrIdx = wrAddr[IDXW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NSETS; s++) begin
        for (int k = 0; k < NCOEF; k++) coefBank[s][k] <= '0;
        rslBank[s].pos <= '0;
        rslBank[s].lo  <= {1'b1, {(DW-1){1'b0}}};
        rslBank[s].hi  <= {1'b0, {(DW-1){1'b1}}};
      end
    end else if (wrEn) begin
      if (!isRsl) begin
        if (int'(wrIdx) < NCOEF) coefBank[wrSet][wrIdx] <= wrData;
      end else begin
        case (wrIdx)
          4'd0: rslBank[wrSet].pos <= wrData[POSW-1:0];
          4'd1: rslBank[wrSet].lo  <= wrData;
          4'd2: rslBank[wrSet].hi  <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefSel1 <= '0;
      passPipe <= '0;
      for (int i = 0; i < DEPTH; i++) rslPipe[i] <= '0;
    end else begin
      coefSel1   <= coefSel;
      passPipe   <= {passPipe[DEPTH-2:0], passMode};
      rslPipe[0] <= rslSel;
      for (int i = 1; i < DEPTH; i++) rslPipe[i] <= rslPipe[i-1];
    end
  end

  generate
    for (genvar k = 0; k < NCOEF; k++) begin : g_coef
      assign coefAct[k] = coefBank[coefSel1][k];
    end
  endgenerate

  assign ctrlBus.bypass = passPipe[DEPTH-1];
  assign ctrlBus.rsl    = rslBank[rslPipe[DEPTH-1]];
endmodule

// File: rtl/csc_rsl.sv
module csc_rsl
  import csc_pkg::*;
(
  input  fld_t     fIn,
  input  rsl_cfg_t cfg,
  output data_t    dOut
);
  logic        [4:0]  rndPos, cutPos;
  logic signed [FW:0] ext, rounded, shifted, loExt, hiExt;

  always_comb begin
    rndPos  = 5'(GUARD - 1) - {3'b0, cfg.pos};
    cutPos  = 5'(GUARD)     - {3'b0, cfg.pos};
    ext     = {fIn[FW-1], fIn};
    rounded = ext + ((FW+1)'(1) << rndPos);
    shifted = rounded >>> cutPos;
    loExt   = {{(FW+1-DW){cfg.lo[DW-1]}}, cfg.lo};
    hiExt   = {{(FW+1-DW){cfg.hi[DW-1]}}, cfg.hi};
    if (shifted < loExt)      dOut = cfg.lo;
    else if (shifted > hiExt) dOut = cfg.hi;
    else                      dOut = shifted[DW-1:0];
  end
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  data_t     dIn     [NCH],
  input  coef_t     coefAct [NCOEF],
  input  csc_ctrl_t ctrlBus,
  output data_t     dOut    [NCH]
);
  data_t raw1 [NCH];
  data_t raw2 [NCH];
  data_t raw3 [NCH];
  prod_t prod [NCOEF];
  sum_t  acc  [NROW];
  prod_t keyAcc;
  fld_t  fld  [NCH];
  data_t shaped [NCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        raw1[i] <= '0; raw2[i] <= '0; raw3[i] <= '0; dOut[i] <= '0;
      end
      for (int k = 0; k < NCOEF; k++) prod[k] <= '0;
      for (int r = 0; r < NROW; r++) acc[r] <= '0;
      keyAcc <= '0;
    end else begin
      raw1 <= dIn;
      raw2 <= raw1;
      raw3 <= raw2;
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NROW; c++)
          prod[r*NROW+c] <= coefAct[r*NROW+c] * raw1[c];
      prod[NCOEF-1] <= coefAct[NCOEF-1] * raw1[NCH-1];
      for (int r = 0; r < NROW; r++)
        acc[r] <= sum_t'(prod[r*NROW]) + sum_t'(prod[r*NROW+1]) + sum_t'(prod[r*NROW+2]);
      keyAcc <= prod[NCOEF-1];
      for (int i = 0; i < NCH; i++)
        dOut[i] <= ctrlBus.bypass ? raw3[i] : shaped[i];
    end
  end

  generate
    for (genvar r = 0; r < NROW; r++) begin : g_fld
      assign fld[r] = acc[r][SW-1 -: FW];
    end
  endgenerate
  assign fld[NCH-1] = keyAcc[PW-1 -: FW];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_rsl
      csc_rsl u_rsl (.fIn(fld[i]), .cfg(ctrlBus.rsl), .dOut(shaped[i]));
    end
  endgenerate
endmodule

// File: rtl/csc_matrix_top.sv
module csc_matrix_top
  import csc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [AW-1:0]          wrAddr,
  input  logic [DW-1:0]          wrData,
  input  logic [SELW-1:0]        coefSel,
  input  logic [SELW-1:0]        rslSel,
  input  logic                   passMode,
  input  logic signed [DW-1:0]   inA,
  input  logic signed [DW-1:0]   inB,
  input  logic signed [DW-1:0]   inC,
  input  logic signed [DW-1:0]   inD,
  output logic signed [DW-1:0]   outW,
  output logic signed [DW-1:0]   outX,
  output logic signed [DW-1:0]   outY,
  output logic signed [DW-1:0]   outZ
);
  coef_t     coefAct [NCOEF];
  csc_ctrl_t ctrlBus;
  data_t     dIn  [NCH];
  data_t     dOut [NCH];

  assign dIn[0] = inA;
  assign dIn[1] = inB;
  assign dIn[2] = inC;
  assign dIn[3] = inD;

  csc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .coefSel(coefSel), .rslSel(rslSel), .passMode(passMode),
    .coefAct(coefAct), .ctrlBus(ctrlBus)
  );

  csc_datapath u_dp (
    .clk(clk), .rstN(rstN), .dIn(dIn), .coefAct(coefAct),
    .ctrlBus(ctrlBus), .dOut(dOut)
  );

  assign outW = dOut[0];
  assign outX = dOut[1];
  assign outY = dOut[2];
  assign outZ = dOut[3];
endmodule

// File: rtl/csc_matrix_checker.sv
module csc_matrix_checker
  import csc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 passMode,
  input logic signed [DW-1:0] inA,
  input logic signed [DW-1:0] inD,
  input logic signed [DW-1:0] outW,
  input logic signed [DW-1:0] outZ,
  input logic                 bypassNow,
  input logic signed [DW-1:0] loNow,
  input logic signed [DW-1:0] hiNow
);
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (warm != 3'd5) warm <= warm + 3'd1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |-> (outW == '0 && outZ == '0)); // R1

  AST_PASS_W: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd5 && $past(passMode, 4)) |-> outW == $past(inA, 4)); // R10

  AST_PASS_Z: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd5 && $past(passMode, 4)) |-> outZ == $past(inD, 4)); // R10

  AST_CLAMP_W: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && !$past(bypassNow) && $past(loNow) <= $past(hiNow))
      |-> (outW >= $past(loNow) && outW <= $past(hiNow))); // R7

  AST_CLAMP_Z: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 3'd2 && !$past(bypassNow) && $past(loNow) <= $past(hiNow))
      |-> (outZ >= $past(loNow) && outZ <= $past(hiNow))); // R7
endmodule

bind csc_matrix_top csc_matrix_checker u_chk (
  .clk(clk), .rstN(rstN), .passMode(passMode), .inA(inA), .inD(inD),
  .outW(outW), .outZ(outZ), .bypassNow(ctrlBus.bypass),
  .loNow(ctrlBus.rsl.lo), .hiNow(ctrlBus.rsl.hi)
);

// File: tb/tb_csc_matrix_top.sv
module tb_csc_matrix_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXPIX = 16;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn;
  logic [6:0] wrAddr;
  logic [12:0] wrData;
  logic [1:0] coefSel, rslSel;
  logic passMode;
  logic signed [12:0] inA, inB, inC, inD;
  logic signed [12:0] outW, outX, outY, outZ;

  int nChecks = 0;
  int nErrors = 0;

  int cB [4][10];
  int posB [4], loB [4], hiB [4];

  int pA [MAXPIX], pB [MAXPIX], pC [MAXPIX], pD [MAXPIX];
  int pCs [MAXPIX], pRs [MAXPIX];
  bit pP [MAXPIX];

  csc_matrix_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .coefSel(coefSel), .rslSel(rslSel), .passMode(passMode),
    .inA(inA), .inB(inB), .inC(inC), .inD(inD),
    .outW(outW), .outX(outX), .outY(outY), .outZ(outZ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(int kind, int set, int idx, int val);
    wrEn   = 1'b1;
    wrAddr = {kind[0], set[1:0], idx[3:0]};
    wrData = val[12:0];
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic setCoef(int set, int idx, int val);
    wr(0, set, idx, val);
    cB[set][idx] = val;
  endtask

  task automatic setRsl(int set, int pos, int lo, int hi);
    wr(1, set, 0, pos); wr(1, set, 1, lo); wr(1, set, 2, hi);
    posB[set] = pos; loB[set] = lo; hiB[set] = hi;
  endtask

  // Independent model of R3..R7 and R10
  function automatic int model(int ch, int i);
    longint acc, pre;
    int p, rs;
    if (pP[i]) begin
      case (ch) 0: return pA[i]; 1: return pB[i]; 2: return pC[i]; default: return pD[i]; endcase
    end
    rs = pRs[i];
    p  = posB[rs];
    if (ch < 3) begin
      acc = longint'(cB[pCs[i]][ch*3])   * pA[i]
          + longint'(cB[pCs[i]][ch*3+1]) * pB[i]
          + longint'(cB[pCs[i]][ch*3+2]) * pC[i];
      pre = (acc + (longint'(1) << (14 - p))) >>> (15 - p);
    end else begin
      acc = longint'(cB[pCs[i]][9]) * pD[i];
      pre = (acc + (longint'(1) << (12 - p))) >>> (13 - p);
    end
    if (pre < loB[rs]) return loB[rs];
    if (pre > hiB[rs]) return hiB[rs];
    return int'(pre);
  endfunction

  task automatic drivePix(int i);
    inA = pA[i][12:0]; inB = pB[i][12:0]; inC = pC[i][12:0]; inD = pD[i][12:0];
    coefSel = pCs[i][1:0]; rslSel = pRs[i][1:0]; passMode = pP[i];
  endtask

  task automatic driveIdle();
    inA = '0; inB = '0; inC = '0; inD = '0;
    coefSel = '0; rslSel = '0; passMode = 1'b0;
  endtask

  task automatic setPix(int i, int a, int b, int c, int d, int cs, int rs, bit ps);
    pA[i] = a; pB[i] = b; pC[i] = c; pD[i] = d; pCs[i] = cs; pRs[i] = rs; pP[i] = ps;
  endtask

  // Stream n pixels back to back; result of pixel i checked four edges later
  task automatic runStream(int n, string tagM, string tagZ);
    for (int i = 0; i < n + 4; i++) begin
      if (i >= 4) begin
        chk(tagM, "W", int'(outW), model(0, i-4));
        chk(tagM, "X", int'(outX), model(1, i-4));
        chk(tagM, "Y", int'(outY), model(2, i-4));
        chk(tagZ, "Z", int'(outZ), model(3, i-4));
      end
      if (i < n) drivePix(i); else driveIdle();
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; driveIdle();
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 10; k++) cB[s][k] = 0;
      posB[s] = 0; loB[s] = -4096; hiB[s] = 4095;
    end
    repeat (3) @(negedge clk);
    chk("R1", "W in reset", int'(outW), 0);
    chk("R1", "Z in reset", int'(outZ), 0);
    inA = 13'sd1000; inD = -13'sd1000; passMode = 1'b1;
    @(negedge clk);
    chk("R1", "X held in reset", int'(outX), 0);
    driveIdle();
    rstN = 1'b1;
    @(negedge clk);
    // zero coefficients after reset give zero results
    setPix(0, 4000, -4000, 123, 4095, 1, 2, 0);
    setPix(1, -4096, 17, 4095, -4096, 3, 3, 0);
    runStream(2, "R1", "R1");
  endtask

  task automatic t_matrix();
    setCoef(0, 0, 2048);  setCoef(0, 1, 1024); setCoef(0, 2, -512);
    setCoef(0, 3, -1024); setCoef(0, 4, 2048); setCoef(0, 5, 0);
    setCoef(0, 6, 4095);  setCoef(0, 7, -4096); setCoef(0, 8, 100);
    setCoef(0, 9, 3000);
    setRsl(0, 3, -4096, 4095);
    setPix(0, 100, 200, 300, 400, 0, 0, 0);
    setPix(1, -4096, 4095, -1, -4096, 0, 0, 0);
    setPix(2, 0, 0, 0, 0, 0, 0, 0);
    setPix(3, 4095, 4095, 4095, 4095, 0, 0, 0);
    setPix(4, -1234, 567, 890, -2000, 0, 0, 0);
    runStream(5, "R3", "R4");
  endtask

  task automatic t_window();
    setRsl(1, 0, -4096, 4095);
    setRsl(2, 1, -4096, 4095);
    setRsl(3, 2, -4096, 4095);
    for (int i = 0; i < 8; i++)
      setPix(i, 4000 - i*997, -3000 + i*611, 2500 - i*333, -4000 + i*1001, 0, i % 4, 0);
    runStream(8, "R5", "R5");
    // per-clock shaping-set switching with one repeated pixel
    for (int i = 0; i < 6; i++) setPix(i, 3333, -2222, 1111, 2500, 0, (i * 3) % 4, 0);
    runStream(6, "R9", "R9");
  endtask

  task automatic t_round();
    setCoef(2, 0, 2048); setCoef(2, 1, 0); setCoef(2, 2, 0);
    setCoef(2, 3, 0); setCoef(2, 4, 2048); setCoef(2, 5, 0);
    setCoef(2, 6, 0); setCoef(2, 7, 0); setCoef(2, 8, 2048);
    setCoef(2, 9, 512);
    setPix(0, 3, -3, 5, 3, 2, 0, 0);
    setPix(1, -5, 1, -1, -3, 2, 0, 0);
    runStream(2, "R6", "R6");
    // explicit half-way values: 1.5 -> 2, -1.5 -> -1
    chk("R6", "+1.5", model(0, 0), 2);
    chk("R6", "-1.5", model(1, 0), -1);
  endtask

  task automatic t_clamp();
    setRsl(3, 3, -100, 100);
    setPix(0, 4000, 0, 0, 4000, 0, 3, 0);
    setPix(1, -4000, 0, 0, -4000, 0, 3, 0);
    setPix(2, 50, 60, 70, 20, 0, 3, 0);
    runStream(3, "R7", "R7");
    chk("R7", "ceiling value", model(0, 0), 100);
  endtask

  task automatic t_coefSwitch();
    for (int i = 0; i < 8; i++) setPix(i, 1500, -700, 2900, -1800, (i % 2) * 2, 0, 0);
    runStream(8, "R8", "R8");
  endtask

  task automatic t_pass();
    for (int i = 0; i < 8; i++)
      setPix(i, -4096 + i*1000, 4095 - i*900, i*7, -i*500, 0, 3, (i % 3) != 1);
    runStream(8, "R10", "R10");
  endtask

  task automatic t_latency();
    setPix(0, 1200, 800, -400, 2000, 0, 0, 0);
    driveIdle();
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    drivePix(0);
    @(negedge clk);
    driveIdle();
    @(negedge clk); @(negedge clk);
    chk("R2", "W after 3 edges", int'(outW), 0);
    @(negedge clk);
    chk("R2", "W after 4 edges", int'(outW), model(0, 0));
    chk("R2", "Z after 4 edges", int'(outZ), model(3, 0));
  endtask

  task automatic t_ignored();
    wr(0, 0, 12, 1234);   // unused coefficient index
    wr(0, 0, 15, -77);
    wr(1, 0, 5, 1);       // unused shaping index
    wr(1, 0, 9, -5);
    setPix(0, 100, 200, 300, 400, 0, 0, 0);
    setPix(1, -1234, 567, 890, -2000, 0, 0, 0);
    runStream(2, "R11", "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: run did not finish actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    t_reset();
    t_matrix();
    t_latency();
    t_window();
    t_round();
    t_clamp();
    t_coefSwitch();
    t_pass();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule